// File: doc/BRIEF.md
# DRAM Current-Test Command Sequencer

This block drives a DDR SDRAM command bus with fixed, cycle-exact command loops that hold a memory device in one of two standard supply-current workloads. In the single-bank workload one bank is opened, read with a burst of four, and closed, over and over. In the four-bank workload all four banks are opened in turn and read with auto-precharge, so that activates and reads interleave. A mode input picks the workload. A speed-grade input picks between the 100 MHz loop and the 133 MHz loop, and that choice sets the loop length and where its idle slots fall.

Each output cycle carries one registered command on the strobes, a bank address, a row or column address, and a data-toggle mask for the write-data generator. Row and column addresses come from a 16-bit LFSR that steps once per loop iteration. A run begins on the first clock edge that sees `start_i` high while idle. It continues for as long as `start_i` stays high, and ends only at the close of a whole iteration.

Top module: `ddr_idd_sequencer`

## Requirements
- R1: From reset, and on every cycle with no run in progress, cs_n, ras_n, cas_n and we_n are all 1 and the toggle mask is 0. Reset leaves addr and ba at 0, and idle cycles hold them unchanged.
- R2: Commands are encoded on {ras_n,cas_n,we_n} as activate=011, read=101, precharge=010, NOP=111. cs_n is 0 on every non-NOP cycle and 1 on every NOP cycle.
- R3: Single-bank at 100 MHz (grade 0) repeats 7 cycles: ACT b0, NOP, RD b0, NOP, NOP, PRE b0, NOP.
- R4: Single-bank at 133 MHz (grade 1) repeats 9 cycles: ACT b0, NOP, NOP, RD b0, NOP, PRE b0, NOP, NOP, NOP.
- R5: Four-bank at 100 MHz repeats 8 cycles: ACT b0, RD b3, ACT b1, RD b0, ACT b2, RD b1, ACT b3, RD b2. In the first iteration of a run, slot 1 is a NOP.
- R6: Four-bank at 133 MHz repeats 10 cycles: ACT b0, NOP, ACT b1, RD b0, ACT b2, RD b1, ACT b3, RD b2, NOP, RD b3.
- R7: When start_i is sampled high while idle, the same edge issues slot 0 (ACT bank 0). Mode and grade are captured at that edge, and later changes have no effect until the run ends.
- R8: When start_i is low at the last slot of an iteration, the run ends after that slot, so a one-cycle start pulse yields exactly one iteration.
- R9: The LFSR has seed 0xACE1. Each step shifts left and inserts l[15]^l[13]^l[12]^l[10], once at the last slot of every iteration. An activate drives addr=l[12:0]. A read drives addr[9:0]=l[15:6] and addr[10]=1 in four-bank mode (0 in single-bank), with all other bits 0.
- R10: A precharge drives ba=0 and addr=l[12:0] with bit 10 cleared.
- R11: In single-bank mode each NOP drives addr and ba as the bitwise inverse of their previous-cycle values.
- R12: In four-bank mode each NOP holds addr and ba unchanged.
- R13: During a run the toggle mask has bit i set for every even i in single-bank mode and all bits set in four-bank mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Starts a run when high while idle; keeps it running while high |
| mode_four_i | input | 1 | 0 = single-bank workload, 1 = four-bank workload |
| grade_fast_i | input | 1 | 0 = 100 MHz loop, 1 = 133 MHz loop |
| cs_n_o | output | 1 | Chip select, active low |
| ras_n_o | output | 1 | Row strobe |
| cas_n_o | output | 1 | Column strobe |
| we_n_o | output | 1 | Write enable |
| ba_o | output | 2 | Bank address |
| addr_o | output | ADDR_W (13) | Row/column address |
| toggle_mask_o | output | DATA_W (64) | Data bits to flip per burst |

## Verification
The hardest case to reach from the ports is the first-iteration NOP in the four-bank 100 MHz loop. It appears only in the single iteration that follows a start from idle, so the stimulus starts that workload from idle more than once, and in one of those runs it uses a one-cycle start pulse so that the iteration is both the first and the last. Stopping on the iteration boundary is checked the same way, by releasing start at different slots in every workload. Mode and grade are also changed in the middle of a run to show that they have no effect.

// File: rtl/iddseq_pkg.sv
// Shared types for the current-test sequencer.
// Assumes a 4-bit slot counter covers the longest loop (10 slots).
package iddseq_pkg;

    // Command encoding on {ras_n, cas_n, we_n}
    typedef enum logic [2:0] {
        CMD_ACT = 3'b011,
        CMD_RD  = 3'b101,
        CMD_PRE = 3'b010,
        CMD_NOP = 3'b111
    } cmd_e;

    typedef struct packed {
        cmd_e       cmd;
        logic [1:0] bank;
    } slot_t;

    localparam int STEP_W = 4;
    localparam int LFSR_W = 16;

    // Number of slots in one iteration for a workload / speed grade
    function automatic logic [STEP_W-1:0] loop_len(input logic four, input logic fast);
        if (four) return fast ? 4'd10 : 4'd8;
        else      return fast ? 4'd9  : 4'd7;
    endfunction

endpackage

// File: rtl/iddseq_lfsr.sv
// 16-bit Fibonacci LFSR providing random row/column bits.
// Assumes adv is a single-cycle strobe; value is held otherwise.
module iddseq_lfsr #(
    parameter logic [15:0] SEED = 16'hACE1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        adv,
    output logic [15:0] value
);
    logic fb;

    // Feedback taps for x^16 + x^14 + x^13 + x^11 + 1
    always_comb fb = value[15] ^ value[13] ^ value[12] ^ value[10];

    // Shift once per advance strobe
    always_ff @(posedge clk) begin
        if (!rst_n)   value <= SEED;
        else if (adv) value <= {value[14:0], fb};
    end
endmodule

// File: rtl/iddseq_pattern.sv
// Slot decoder: maps (workload, grade, slot, first-iteration) to a command and bank.
// Purely combinational; assumes step is below loop_len for the selected loop.
module iddseq_pattern
    import iddseq_pkg::*;
(
    input  logic              four,
    input  logic              fast,
    input  logic              first,
    input  logic [STEP_W-1:0] step,
    output slot_t             slot
);
    // Select the command for the current slot
    always_comb begin
        slot.cmd  = CMD_NOP;
        slot.bank = 2'd0;
        if (!four) begin
            if (step == 4'd0)                    slot.cmd = CMD_ACT;
            else if (step == (fast ? 4'd3 : 4'd2)) slot.cmd = CMD_RD;
            else if (step == 4'd5)               slot.cmd = CMD_PRE;
        end else if (fast && step == 4'd8) begin
            slot.cmd = CMD_NOP;
        end else if (fast && step == 4'd9) begin
            slot.cmd  = CMD_RD;
            slot.bank = 2'd3;
        end else if (!step[0]) begin
            slot.cmd  = CMD_ACT;
            slot.bank = step[2:1];
        end else if (step == 4'd1 && (fast || first)) begin
            slot.cmd = CMD_NOP;
        end else begin
            slot.cmd  = CMD_RD;
            slot.bank = step[2:1] - 2'd1;
        end
    end
endmodule

// File: rtl/iddseq_drive.sv
// Output stage: registers the command, bank, address and toggle mask of each slot.
// Assumes COL_W <= 10 so the column never overlaps the auto-precharge bit.
module iddseq_drive
    import iddseq_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int COL_W  = 10,
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue,
    input  logic              four,
    input  slot_t             slot,
    input  logic [LFSR_W-1:0] rnd,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [1:0]        ba,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] mask
);
    localparam int AP_BIT = 10;
    localparam logic [DATA_W-1:0] HALF_MASK = {(DATA_W/2){2'b01}};

    logic [ADDR_W-1:0] row_a, rd_a, pre_a;

    // Form the row, read and precharge addresses from the random word
    always_comb begin
        row_a = rnd[ADDR_W-1:0];
        pre_a = row_a;
        pre_a[AP_BIT] = 1'b0;
        rd_a = '0;
        rd_a[COL_W-1:0] = rnd[LFSR_W-1 -: COL_W];
        rd_a[AP_BIT] = four;
    end

    // Register one slot per cycle, or idle levels when nothing is issued
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            {cs_n, ras_n, cas_n, we_n} <= 4'hF;
            ba   <= '0;
            addr <= '0;
            mask <= '0;
        end else if (!issue) begin
            {cs_n, ras_n, cas_n, we_n} <= 4'hF;
            mask <= '0;
        end else begin
            cs_n <= (slot.cmd == CMD_NOP);
            {ras_n, cas_n, we_n} <= slot.cmd;
            mask <= four ? {DATA_W{1'b1}} : HALF_MASK;
            case (slot.cmd)
                CMD_ACT: begin addr <= row_a; ba <= slot.bank; end
                CMD_RD:  begin addr <= rd_a;  ba <= slot.bank; end
                CMD_PRE: begin addr <= pre_a; ba <= slot.bank; end
                default: if (!four) begin addr <= ~addr; ba <= ~ba; end
            endcase
        end
    end
endmodule

// File: rtl/ddr_idd_sequencer.sv
// Top: replays fixed command loops for single-bank and four-bank current tests.
// Assumes start_i, mode_four_i and grade_fast_i are synchronous to clk.
module ddr_idd_sequencer
    import iddseq_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int COL_W  = 10,
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              mode_four_i,
    input  logic              grade_fast_i,
    output logic              cs_n_o,
    output logic              ras_n_o,
    output logic              cas_n_o,
    output logic              we_n_o,
    output logic [1:0]        ba_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DATA_W-1:0] toggle_mask_o
);
    logic              run_q, first_q, four_q, fast_q;
    logic [STEP_W-1:0] step_q;
    logic              cur_four, cur_fast, cur_first, issue, last;
    logic [STEP_W-1:0] cur_step;
    logic [LFSR_W-1:0] rnd;
    slot_t             slot;

    // Choose live or captured loop settings for this cycle
    always_comb begin
        cur_four  = run_q ? four_q  : mode_four_i;
        cur_fast  = run_q ? fast_q  : grade_fast_i;
        cur_step  = run_q ? step_q  : '0;
        cur_first = run_q ? first_q : 1'b1;
        issue     = run_q | start_i;
        last      = (cur_step == loop_len(cur_four, cur_fast) - 4'd1);
    end

    // Run control: capture settings, step slots, stop on iteration boundary
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= 1'b0; first_q <= 1'b0; four_q <= 1'b0; fast_q <= 1'b0;
            step_q <= '0;
        end else if (issue) begin
            if (!run_q) begin
                run_q <= 1'b1; first_q <= 1'b1;
                four_q <= mode_four_i; fast_q <= grade_fast_i;
            end
            if (last) begin
                first_q <= 1'b0;
                step_q  <= '0;
                if (!start_i) run_q <= 1'b0;
            end else begin
                step_q <= cur_step + 4'd1;
            end
        end
    end

    iddseq_lfsr u_lfsr (
        .clk(clk), .rst_n(rst_n), .adv(issue & last), .value(rnd)
    );

    iddseq_pattern u_pat (
        .four(cur_four), .fast(cur_fast), .first(cur_first), .step(cur_step), .slot(slot)
    );

    iddseq_drive #(.ADDR_W(ADDR_W), .COL_W(COL_W), .DATA_W(DATA_W)) u_drv (
        .clk(clk), .rst_n(rst_n), .issue(issue), .four(cur_four), .slot(slot), .rnd(rnd),
        .cs_n(cs_n_o), .ras_n(ras_n_o), .cas_n(cas_n_o), .we_n(we_n_o),
        .ba(ba_o), .addr(addr_o), .mask(toggle_mask_o)
    );
endmodule

// File: rtl/iddseq_checker.sv
// Port-level properties of the sequencer, attached by bind.
// Assumes ADDR_W > 10 so the auto-precharge bit exists.
module iddseq_checker #(
    parameter int ADDR_W = 13,
    parameter int DATA_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_n_o,
    input logic              ras_n_o,
    input logic              cas_n_o,
    input logic              we_n_o,
    input logic [1:0]        ba_o,
    input logic [ADDR_W-1:0] addr_o,
    input logic [DATA_W-1:0] toggle_mask_o
);
    logic is_act, is_rd, is_pre, is_single, is_four, is_idle;

    // Decode port levels into command and workload flags
    always_comb begin
        is_act    = {ras_n_o, cas_n_o, we_n_o} == 3'b011;
        is_rd     = {ras_n_o, cas_n_o, we_n_o} == 3'b101;
        is_pre    = {ras_n_o, cas_n_o, we_n_o} == 3'b010;
        is_single = $countones(toggle_mask_o) == DATA_W/2;
        is_four   = &toggle_mask_o;
        is_idle   = toggle_mask_o == '0;
    end

    AST_CS_FOLLOWS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_o == (ras_n_o & cas_n_o & we_n_o)); // R2
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        is_idle |-> cs_n_o); // R1
    AST_MASK_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        is_idle || is_single || is_four); // R13
    AST_RUN_OPENS_BANK0: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(is_idle) && !is_idle) |-> (is_act && ba_o == 2'd0)); // R7
    AST_FOUR_READ_AP: assert property (@(posedge clk) disable iff (!rst_n)
        (is_rd && is_four) |-> addr_o[10]); // R9
    AST_SINGLE_READ_NO_AP: assert property (@(posedge clk) disable iff (!rst_n)
        (is_rd && is_single) |-> !addr_o[10]); // R9
    AST_PRE_BANK0: assert property (@(posedge clk) disable iff (!rst_n)
        is_pre |-> (ba_o == 2'd0 && !addr_o[10])); // R10
    AST_SINGLE_NOP_INVERT: assert property (@(posedge clk) disable iff (!rst_n)
        (is_single && cs_n_o && $past(is_single)) |-> (addr_o == ~$past(addr_o) && ba_o == ~$past(ba_o))); // R11
    AST_FOUR_NOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (is_four && cs_n_o && $past(is_four)) |-> ($stable(addr_o) && $stable(ba_o))); // R12
endmodule

bind ddr_idd_sequencer iddseq_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cs_n_o(cs_n_o), .ras_n_o(ras_n_o), .cas_n_o(cas_n_o),
    .we_n_o(we_n_o), .ba_o(ba_o), .addr_o(addr_o), .toggle_mask_o(toggle_mask_o)
);

// File: tb/test_ddr_idd_sequencer.sv
module test_ddr_idd_sequencer;
    localparam int AW = 13;
    localparam int DW = 64;

    logic clk = 0, rst_n = 0, start = 0, mode = 0, grade = 0;
    logic cs_n, ras_n, cas_n, we_n;
    logic [1:0] ba;
    logic [AW-1:0] addr;
    logic [DW-1:0] mask;

    int errors = 0, checks = 0, cycles = 0;

    always #5 clk = ~clk;

    ddr_idd_sequencer i_ddr_idd_sequencer (
        .clk(clk), .rst_n(rst_n), .start_i(start), .mode_four_i(mode), .grade_fast_i(grade),
        .cs_n_o(cs_n), .ras_n_o(ras_n), .cas_n_o(cas_n), .we_n_o(we_n),
        .ba_o(ba), .addr_o(addr), .toggle_mask_o(mask)
    );

    // ---------------- behavioural reference model ----------------
    // slot codes: 0 NOP, 1 ACT, 2 RD, 3 PRE
    int pc[$], pb[$];
    bit m_run = 0, m_four = 0, m_fast = 0, m_first = 0, e_issue = 0;
    int m_idx = 0;
    logic [15:0] lf = 16'hACE1;
    logic [3:0]  e_cmd = 4'hF;      // {cs_n, ras_n, cas_n, we_n}
    logic [1:0]  e_ba = 0;
    logic [AW-1:0] e_addr = 0;
    logic [DW-1:0] e_mask = 0;

    task automatic build();
        if (!m_four && !m_fast) begin pc = '{1,0,2,0,0,3,0};          pb = '{0,0,0,0,0,0,0}; end
        if (!m_four &&  m_fast) begin pc = '{1,0,0,2,0,3,0,0,0};      pb = '{0,0,0,0,0,0,0,0,0}; end
        if ( m_four && !m_fast) begin pc = '{1,2,1,2,1,2,1,2};        pb = '{0,3,1,0,2,1,3,2}; end
        if ( m_four &&  m_fast) begin pc = '{1,0,1,2,1,2,1,2,0,2};    pb = '{0,0,1,0,2,1,3,2,0,3}; end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_run = 0; lf = 16'hACE1; e_cmd = 4'hF; e_ba = 0; e_addr = 0; e_mask = 0; e_issue = 0;
        end else begin
            if (!m_run && start) begin
                m_run = 1; m_four = mode; m_fast = grade; m_idx = 0; m_first = 1; build();
            end
            e_issue = m_run;
            if (m_run) begin
                int c;
                c = pc[m_idx];
                if (m_four && !m_fast && m_idx == 1 && m_first) c = 0;
                e_mask = m_four ? {DW{1'b1}} : {(DW/2){2'b01}};
                case (c)
                    1: begin e_cmd = 4'b0011; e_addr = lf[AW-1:0]; e_ba = pb[m_idx][1:0]; end
                    2: begin e_cmd = 4'b0101; e_addr = '0; e_addr[9:0] = lf[15:6];
                             e_addr[10] = m_four; e_ba = pb[m_idx][1:0]; end
                    3: begin e_cmd = 4'b0010; e_addr = lf[AW-1:0]; e_addr[10] = 1'b0; e_ba = 0; end
                    default: begin e_cmd = 4'b1111;
                             if (!m_four) begin e_addr = ~e_addr; e_ba = ~e_ba; end end
                endcase
                if (m_idx == pc.size() - 1) begin
                    lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
                    m_first = 0; m_idx = 0;
                    if (!start) m_run = 0;
                end else m_idx++;
            end else begin
                e_cmd = 4'hF; e_mask = 0;
            end
        end
    end

    // ---------------- comparison on every clock ----------------
    task automatic chk(input bit ok, input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h at t=%0t", req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            string pt;
            pt = !e_issue ? "R1" : m_four ? (m_fast ? "R6" : "R5") : (m_fast ? "R4" : "R3");
            chk({cs_n, ras_n, cas_n, we_n} == e_cmd, pt, "cmd", {cs_n, ras_n, cas_n, we_n}, e_cmd);
            chk(cs_n == (ras_n & cas_n & we_n), "R2", "cs_n vs cmd", cs_n, ras_n & cas_n & we_n);
            chk(addr == e_addr, !e_issue ? "R1" : e_cmd[0] && e_cmd[3] ? (m_four ? "R12" : "R11")
                : e_cmd == 4'b0010 ? "R10" : "R9", "addr", addr, e_addr);
            chk(ba == e_ba, e_cmd == 4'b1111 && e_issue ? (m_four ? "R12" : "R11") : pt, "ba", ba, e_ba);
            chk(mask == e_mask, "R13", "mask", mask, e_mask);
        end
    end

    // ---------------- watchdog ----------------
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            errors++;
            $display("FAIL watchdog: actual=%0d expected<=20000 cycles", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    function automatic int len_of(bit f, bit g);
        return f ? (g ? 10 : 8) : (g ? 9 : 7);
    endfunction

    task automatic run(input bit f, input bit g, input int iters, input int drop_at);
        @(negedge clk); mode = f; grade = g; start = 1;
        @(negedge clk);
        chk({ras_n, cas_n, we_n} == 3'b011 && ba == 0, "R7", "first slot ACT b0",
            {ras_n, cas_n, we_n, ba}, 5'b01100);
        repeat ((iters - 1) * len_of(f, g) + drop_at - 1) @(negedge clk);
        start = 0;
        repeat (len_of(f, g) + 3) @(negedge clk);
        chk(mask == 0 && cs_n, "R8", "idle after stop", mask, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk({cs_n, ras_n, cas_n, we_n} == 4'hF && mask == 0 && addr == 0 && ba == 0,
            "R1", "reset state", {cs_n, ras_n, cas_n, we_n}, 4'hF);
        rst_n = 1;
        repeat (3) @(negedge clk);

        run(0, 0, 3, 4);   // R3
        run(0, 1, 3, 8);   // R4
        run(1, 0, 3, 2);   // R5
        run(1, 1, 3, 9);   // R6

        // R5 first-iteration NOP with a one-cycle pulse (R8: exactly one iteration)
        for (int g = 0; g < 2; g++) begin
            int live;
            live = 0;
            @(negedge clk); mode = 1; grade = g[0]; start = 1;
            @(negedge clk); start = 0;
            if (mask != 0) live++;
            for (int k = 0; k < 14; k++) begin
                @(negedge clk);
                if (mask != 0) live++;
            end
            chk(live == len_of(1, g[0]), "R8", "slots after pulse", live, len_of(1, g[0]));
        end

        // R7: mode and grade changes mid-run have no effect
        @(negedge clk); mode = 0; grade = 1; start = 1;
        repeat (4) @(negedge clk);
        mode = 1; grade = 0;
        repeat (12) @(negedge clk);
        chk(mask == {(DW/2){2'b01}}, "R7", "workload kept", mask, {(DW/2){2'b01}});
        start = 0;
        repeat (12) @(negedge clk);

        // back-to-back restart in single-bank 100 MHz
        run(0, 0, 2, 7);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule